// File: doc/BRIEF.md
# Byte-Serial CRC Update Unit

This unit advances a 32-bit CRC running state over a short message taken from a 64-bit operand. The message length is one, two, four or eight bytes, picked by a two-bit size code. Operand bytes above the chosen length are discarded. Bytes enter the state starting from the least significant byte, as they would sit in little-endian memory. A mode input selects between two bit-reflected polynomials: the common CRC-32 polynomial and the Castagnoli (CRC-32C) polynomial.

The update is raw. The caller's state goes in unchanged and the resulting state comes out unchanged, with no complement at either end, so a caller can chain several operations over a longer stream. A one-cycle start pulse launches an operation. The unit then spends one clock per byte and raises a one-cycle done pulse when the final state is ready. The 32-bit result is presented sign-extended to 64 bits and holds until the next accepted start. A start that arrives while an operation is running is ignored.

Top module: `crc_step_unit`

## Requirements
- R1: After reset, busy and done are 0 and result is all zeros.
- R2: Size code 0, 1, 2 and 3 selects 1, 2, 4 and 8 message bytes. A start accepted at clock edge k makes done 1 after edge k+N, where N is the byte count, and busy is 1 in the N cycles before that.
- R3: Message bytes are taken least significant byte first. Operand bits at position 8*N and above have no effect on the result.
- R4: Mode 0 uses the reflected polynomial 0xEDB88320 and mode 1 uses 0x82F63B78. For each byte, the byte is XORed into state bits 7:0. Eight right-shift steps follow, and each step XORs in the polynomial when the bit shifted out is 1.
- R5: No inversion is applied. A zero state with an all-zero message gives a zero result, and the result equals the raw bitwise update of state_in.
- R6: result[63:32] always equals 32 copies of result[31].
- R7: A start while busy is 1 is ignored. The run in progress finishes with its original timing and its original result.
- R8: done stays high for exactly one cycle. While no start is accepted, result stays stable after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, accepted only while busy is 0 |
| mode | input | 1 | Polynomial select: 0 = CRC-32, 1 = CRC-32C |
| size_code | input | 2 | Message length: 0 = 1 byte, 1 = 2, 2 = 4, 3 = 8 |
| state_in | input | 32 | Running CRC state to update |
| msg_in | input | 64 | Message operand, little-endian byte order |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when result holds the final state |
| result | output | 64 | Updated state, sign-extended from bit 31 |

## Verification
The start pulse is driven on a falling edge, so the unit accepts it at the next rising edge. The unit then spends one edge per byte, which places done exactly N falling edges after the start is dropped. The bench samples busy one falling edge after acceptance. It checks that done is still low one falling edge before the expected edge, then samples done and result on that edge. For runs that ignore a start, and for checks that result holds, the bench samples again several falling edges later without accepting a new start. Expected results come from a bit-at-a-time reference that feeds message bits in order instead of whole bytes.

// File: rtl/crc_unit_pkg.sv
package crc_unit_pkg;
  localparam int STATE_W   = 32;
  localparam int MSG_W     = 64;
  localparam int BYTE_W    = 8;
  localparam int SIZE_W    = 2;
  localparam int MSG_BYTES = MSG_W / BYTE_W;
  localparam int CNT_W     = $clog2(MSG_BYTES + 1);

  typedef enum logic {
    CRC_MODE_IEEE = 1'b0,
    CRC_MODE_CAST = 1'b1
  } crc_mode_e;

  // Number of bytes encoded by a size code: 1 << code.
  function automatic logic [CNT_W-1:0] bytes_for_size(input logic [SIZE_W-1:0] code);
    bytes_for_size = CNT_W'(1) << code;
  endfunction

  // Clear every operand byte at or above the selected length.
  function automatic logic [MSG_W-1:0] mask_operand(input logic [MSG_W-1:0] msg,
                                                    input logic [SIZE_W-1:0] code);
    logic [MSG_W-1:0] kept;
    int unsigned      nb;
    nb   = int'(bytes_for_size(code));
    kept = '0;
    for (int b = 0; b < MSG_BYTES; b++) begin
      if (b < nb) kept[b*BYTE_W +: BYTE_W] = msg[b*BYTE_W +: BYTE_W];
    end
    mask_operand = kept;
  endfunction

  // One reflected shift step: shift right, fold polynomial if bit 0 was set.
  function automatic logic [STATE_W-1:0] reflect_step(input logic [STATE_W-1:0] st,
                                                      input logic [STATE_W-1:0] poly);
    reflect_step = (st >> 1) ^ (st[0] ? poly : '0);
  endfunction

  function automatic logic [MSG_W-1:0] sign_widen(input logic [STATE_W-1:0] st);
    sign_widen = {{(MSG_W-STATE_W){st[STATE_W-1]}}, st};
  endfunction
endpackage

// File: rtl/crc_byte_engine.sv
module crc_byte_engine
  import crc_unit_pkg::*;
(
  input  logic [STATE_W-1:0] state_cur,
  input  logic [BYTE_W-1:0]  data_byte,
  input  logic [STATE_W-1:0] poly,
  output logic [STATE_W-1:0] state_nxt
);
  logic [STATE_W-1:0] stage [0:BYTE_W];

  assign stage[0] = state_cur ^ {{(STATE_W-BYTE_W){1'b0}}, data_byte};

  for (genvar s = 0; s < BYTE_W; s++) begin : g_step
    assign stage[s+1] = reflect_step(stage[s], poly);
  end

  assign state_nxt = stage[BYTE_W];
endmodule

// File: rtl/crc_operand_reg.sv
module crc_operand_reg
  import crc_unit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [MSG_W-1:0]  msg_in,
  input  logic [SIZE_W-1:0] size_code,
  output logic [BYTE_W-1:0] low_byte
);
  logic [MSG_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (load) begin
      hold_q <= mask_operand(msg_in, size_code);
    end else if (shift) begin
      hold_q <= hold_q >> BYTE_W;
    end
  end

  assign low_byte = hold_q[BYTE_W-1:0];
endmodule

// File: rtl/crc_seq_ctrl.sv
module crc_seq_ctrl
  import crc_unit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SIZE_W-1:0] size_code,
  output logic              accept,
  output logic              step,
  output logic              last_byte,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  bytes_left
);
  logic             busy_q, done_q;
  logic [CNT_W-1:0] left_q;

  assign accept    = start && !busy_q;
  assign step      = busy_q;
  assign last_byte = busy_q && (left_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      left_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      left_q <= bytes_for_size(size_code);
    end else if (busy_q) begin
      left_q <= left_q - CNT_W'(1);
      busy_q <= !last_byte;
      done_q <= last_byte;
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign bytes_left = left_q;
endmodule

// File: rtl/crc_step_unit.sv
module crc_step_unit
  import crc_unit_pkg::*;
#(
  parameter logic [STATE_W-1:0] POLY_IEEE = 32'hEDB88320,
  parameter logic [STATE_W-1:0] POLY_CAST = 32'h82F63B78
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode,
  input  logic [SIZE_W-1:0] size_code,
  input  logic [STATE_W-1:0] state_in,
  input  logic [MSG_W-1:0]  msg_in,
  output logic              busy,
  output logic              done,
  output logic [MSG_W-1:0]  result
);
  logic               accept_w, step_w, last_w;
  logic [CNT_W-1:0]   bytes_left_w;
  logic [BYTE_W-1:0]  cur_byte_w;
  logic [STATE_W-1:0] state_q, state_nxt_w, poly_w;
  crc_mode_e          mode_q;

  crc_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .size_code(size_code),
    .accept(accept_w), .step(step_w), .last_byte(last_w),
    .busy(busy), .done(done), .bytes_left(bytes_left_w)
  );

  crc_operand_reg u_opnd (
    .clk(clk), .rst_n(rst_n), .load(accept_w), .shift(step_w),
    .msg_in(msg_in), .size_code(size_code), .low_byte(cur_byte_w)
  );

  assign poly_w = (mode_q == CRC_MODE_CAST) ? POLY_CAST : POLY_IEEE;

  crc_byte_engine u_engine (
    .state_cur(state_q), .data_byte(cur_byte_w), .poly(poly_w),
    .state_nxt(state_nxt_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      mode_q  <= CRC_MODE_IEEE;
    end else if (accept_w) begin
      state_q <= state_in;
      mode_q  <= crc_mode_e'(mode);
    end else if (step_w) begin
      state_q <= state_nxt_w;
    end
  end

  assign result = sign_widen(state_q);
endmodule

// File: rtl/crc_step_unit_chk.sv
module crc_step_unit_chk
  import crc_unit_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             last_byte,
  input logic [CNT_W-1:0] bytes_left,
  input logic [MSG_W-1:0] result
);
  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: result holds while idle and no start arrives
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));

  // R6: upper half mirrors the sign bit
  p_sign_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    result[MSG_W-1:STATE_W] == {(MSG_W-STATE_W){result[STATE_W-1]}});

  // R2: a running operation always has bytes outstanding
  p_left_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bytes_left != '0));

  // R2: the final byte is followed by done
  p_last_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte |=> (done && !busy));

  // R7: a start while busy does not cut the run short or restart it
  p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last_byte) |=> (busy && bytes_left == $past(bytes_left) - CNT_W'(1)));
endmodule

bind crc_step_unit crc_step_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .last_byte(last_w), .bytes_left(bytes_left_w), .result(result)
);

// File: tb/crc_step_unit_tb.sv
module crc_step_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [1:0]  size_code = 2'd0;
  logic [31:0] state_in = '0;
  logic [63:0] msg_in = '0;
  logic        busy, done;
  logic [63:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  crc_step_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .size_code(size_code),
    .state_in(state_in), .msg_in(msg_in), .busy(busy), .done(done), .result(result)
  );

  // Reference: one message bit at a time, low bit first.
  function automatic logic [63:0] model(input logic m, input logic [1:0] sz,
                                        input logic [31:0] st, input logic [63:0] msg);
    logic [31:0] c, p;
    logic        fb;
    int          nbits;
    p     = m ? 32'h82F63B78 : 32'hEDB88320;
    nbits = 8 << sz;
    c     = st;
    for (int i = 0; i < nbits; i++) begin
      fb = c[0] ^ msg[i];
      c  = {1'b0, c[31:1]};
      if (fb) c = c ^ p;
    end
    return {{32{c[31]}}, c};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Run one operation and check its timing and result.
  task automatic run_op(input logic m, input logic [1:0] sz, input logic [31:0] st,
                        input logic [63:0] msg, output logic [63:0] got);
    int n;
    n = 1 << sz;
    @(negedge clk);
    mode = m; size_code = sz; state_in = st; msg_in = msg; start = 1'b1;
    @(negedge clk);
    start = 1'b0; msg_in = ~msg; state_in = ~st;
    check("R2 busy after accept", {63'd0, busy}, 64'd1);
    for (int k = 1; k < n; k++) @(negedge clk);
    check("R2 done not early", {63'd0, done}, 64'd0);
    @(negedge clk);
    check("R2 done on byte count", {63'd0, done}, 64'd1);
    check("R4 result", result, model(m, sz, st, msg));
    check("R6 sign extension", {32'd0, result[63:32]}, {32'd0, {32{result[31]}}});
    got = result;
  endtask

  logic [63:0] r_a, r_b;
  logic [63:0] pats [0:5];

  initial begin
    pats[0] = 64'h0000_0000_0000_0000;
    pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'h0123_4567_89AB_CDEF;
    pats[3] = 64'h8000_0000_0000_0001;
    pats[4] = 64'hA5A5_5A5A_3C3C_C3C3;
    pats[5] = 64'h0000_00FF_0000_0080;

    repeat (3) @(negedge clk);
    check("R1 busy reset", {63'd0, busy}, 64'd0);
    check("R1 done reset", {63'd0, done}, 64'd0);
    check("R1 result reset", result, 64'd0);
    rst_n = 1'b1;

    // R5: zero in, zero out, both modes
    run_op(1'b0, 2'd3, 32'd0, 64'd0, r_a);
    check("R5 zero crc32", r_a, 64'd0);
    run_op(1'b1, 2'd3, 32'd0, 64'd0, r_a);
    check("R5 zero crc32c", r_a, 64'd0);

    // R4 sweep across modes, sizes, states and patterns
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 6; p++) begin
          run_op(m[0], s[1:0], 32'hFFFF_FFFF ^ (p * 32'h1111_1111), pats[p], r_a);
        end

    // R3: garbage above the selected size has no effect; byte order matters
    for (int s = 0; s < 3; s++) begin
      run_op(1'b0, s[1:0], 32'h1234_5678, 64'h0000_0000_0000_00C7 | (64'hDEAD_BEEF_CAFE_F00D << (8 << s)), r_a);
      run_op(1'b0, s[1:0], 32'h1234_5678, 64'h0000_0000_0000_00C7, r_b);
      check("R3 upper bytes ignored", r_a, r_b);
    end
    run_op(1'b1, 2'd1, 32'd0, 64'h0000_0000_0000_0201, r_a);
    check("R3 low byte first", r_a, model(1'b1, 2'd0, model(1'b1, 2'd0, 32'd0, 64'h01)[31:0], 64'h02));

    // R7: start while busy is ignored
    @(negedge clk);
    mode = 1'b0; size_code = 2'd3; state_in = 32'hCAFE_0001; msg_in = 64'h1122_3344_5566_7788; start = 1'b1;
    @(negedge clk);
    mode = 1'b1; size_code = 2'd0; state_in = 32'h0; msg_in = 64'hFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7 still busy", {63'd0, busy}, 64'd1);
    for (int k = 2; k < 8; k++) @(negedge clk);
    check("R7 done not early", {63'd0, done}, 64'd0);
    @(negedge clk);
    check("R7 done timing", {63'd0, done}, 64'd1);
    check("R7 original result", result, model(1'b0, 2'd3, 32'hCAFE_0001, 64'h1122_3344_5566_7788));

    // R8: single-cycle done, result held
    r_a = result;
    @(negedge clk);
    check("R8 done drops", {63'd0, done}, 64'd0);
    repeat (4) @(negedge clk);
    check("R8 result held", result, r_a);

    // Random runs
    for (int t = 0; t < 150; t++) begin
      logic [63:0] rm;
      rm = {$urandom, $urandom};
      run_op(1'($urandom), 2'($urandom), 32'($urandom), rm, r_a);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule